// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller collects level-sensitive event requests from eight sources and selects the most urgent enabled one. When a request wins, the controller raises an interrupt line to the processor and holds it there. When the processor returns an acknowledge, the controller puts a vector number on its output for a single clock and records the granted level as in service. The vector is the winning source number added to a programmable base, so the processor can use it directly as an index into its table of service-routine pointers.

Priority is fixed by input position, with source 7 the most urgent. A mask register, written through a simple write strobe, can block each source on its own. The in-service record allows nesting. While a level is being serviced, requests at or below that level are held back, but a strictly higher request raises the interrupt line again and can preempt the running routine. An end-of-service strobe retires the highest level that is currently in service.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `irq_o`, `vec_valid_o` and `in_service_o` are all zero, and the mask register holds all ones, so that every source is blocked.
- R2: An enabled request on `req_i` that stays asserted causes `irq_o` to rise on the second rising clock edge after it appears. `irq_o` then stays high, as a level, until the edge that samples `ack_i`.
- R3: When `ack_i` is sampled while `irq_o` is high, `irq_o` falls at that edge. `vec_valid_o` is high for exactly the one following clock, and `vec_o` equals `vec_base_i` plus the winning source number.
- R4: When several enabled requests are pending, the one with the highest input index wins (index 7 is the most urgent).
- R5: A source whose mask bit is 1 (bit i of `mask_wdata_i` belongs to source i, written when `mask_we_i` is high) never raises `irq_o` and is never granted.
- R6: A grant sets bit i of `in_service_o` for the granted source i. While any bit is set, requests at or below the highest set in-service index do not raise `irq_o`.
- R7: A request strictly above the highest in-service level raises `irq_o` again. Its grant adds a second in-service bit and keeps the first one.
- R8: A one-clock pulse on `eoi_i` clears only the highest set bit of `in_service_o`.
- R9: If every eligible request disappears before the acknowledge, `irq_o` falls. A later `ack_i` then produces no vector and leaves `in_service_o` unchanged.
- R10: The vector sum is taken modulo 2^8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request levels; bit 7 has the highest priority |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_wdata_i | input | 8 | New mask value; a 1 blocks the source |
| vec_base_i | input | 8 | Base that is added to the source number |
| ack_i | input | 1 | Acknowledge (grant) from the processor |
| eoi_i | input | 1 | End-of-service strobe |
| irq_o | output | 1 | Interrupt request level |
| vec_o | output | 8 | Vector number |
| vec_valid_o | output | 1 | Vector valid, one clock per grant |
| in_service_o | output | 8 | Levels currently in service |

## Verification
The bench targets four corner cases:
- **Grant timing.** It samples the exact clocks of the acknowledge handshake. A design whose vector strobe lasted two clocks, or whose interrupt stayed high after the grant, fails there.
- **Priority and masking.** It applies mixed request patterns with masked winners. A design that encoded from the lowest index, or that masked after encoding, would return the wrong vector.
- **Nesting.** It stacks a high level on top of a low one and then retires them one at a time. A design that cleared every in-service bit on one strobe, or that let equal or lower levels through, fails there.
- **Withdrawn request and vector wrap.** It withdraws a request before the acknowledge, which catches a design that latched a stale winner. It also sets the base near its maximum, which exposes a vector that does not wrap modulo 256.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int DEF_NUM_SRC = 8;
    localparam int DEF_VEC_W   = 8;
endpackage

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] bits_i,
    output logic         any_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        any_o = |bits_i;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (bits_i[i]) idx_o = W'(i);
        end
    end
endmodule

// File: rtl/ivc_level_gate.sv
module ivc_level_gate #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] isr_i,
    output logic [N-1:0] allow_o,
    output logic         top_any_o,
    output logic [W-1:0] top_idx_o
);
    ivc_prio_enc #(.N(N)) u_top (
        .bits_i (isr_i),
        .any_o  (top_any_o),
        .idx_o  (top_idx_o)
    );

    for (genvar g = 0; g < N; g++) begin : g_allow
        localparam logic [W:0] LVL = (W+1)'(g);
        assign allow_o[g] = !top_any_o || (LVL > {1'b0, top_idx_o});
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
    parameter int NUM_SRC = ivc_pkg::DEF_NUM_SRC,
    parameter int VEC_W   = ivc_pkg::DEF_VEC_W,
    localparam int IW     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               mask_we_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    input  logic [VEC_W-1:0]   vec_base_i,
    input  logic               ack_i,
    input  logic               eoi_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               vec_valid_o,
    output logic [NUM_SRC-1:0] in_service_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] req;
        logic [NUM_SRC-1:0] isr;
        logic               irq;
        logic               vval;
        logic [VEC_W-1:0]   vec;
    } st_t;

    st_t st_q, st_d;

    logic [NUM_SRC-1:0] allow, eligible, isr_next;
    logic               top_any, win_any;
    logic [IW-1:0]      top_idx, win_idx;

    ivc_level_gate #(.N(NUM_SRC)) u_gate (
        .isr_i     (st_q.isr),
        .allow_o   (allow),
        .top_any_o (top_any),
        .top_idx_o (top_idx)
    );

    assign eligible = st_q.req & ~st_q.mask & allow;

    ivc_prio_enc #(.N(NUM_SRC)) u_win (
        .bits_i (eligible),
        .any_o  (win_any),
        .idx_o  (win_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vval = 1'b0;
        st_d.req  = req_i;
        if (mask_we_i) st_d.mask = mask_wdata_i;

        isr_next = st_q.isr;
        if (eoi_i && top_any) isr_next[top_idx] = 1'b0;

        if (st_q.irq) begin
            if (ack_i) begin
                st_d.irq = 1'b0;
                if (win_any) begin
                    isr_next[win_idx] = 1'b1;
                    st_d.vval         = 1'b1;
                    st_d.vec          = vec_base_i + VEC_W'(win_idx);
                end
            end else if (!win_any) begin
                st_d.irq = 1'b0;
            end
        end else begin
            st_d.irq = win_any;
        end
        st_d.isr = isr_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o        = st_q.irq;
    assign vec_o        = st_q.vec;
    assign vec_valid_o  = st_q.vval;
    assign in_service_o = st_q.isr;
endmodule

// File: rtl/ivc_chk.sv
module ivc_chk #(
    parameter int NUM_SRC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_i,
    input logic               irq_o,
    input logic               vec_valid_o,
    input logic [NUM_SRC-1:0] in_service_o
);
    // R3: the vector strobe lasts one clock
    a_r3_one_clock_vector: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);

    // R3: a vector only follows an acknowledge of a raised request
    a_r3_vector_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> ($past(ack_i) && $past(irq_o)));

    // R3: the request level drops once the acknowledge is taken
    a_r3_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !irq_o);

    // R6: a grant records its level
    a_r6_grant_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (in_service_o != '0));

    // R7: at most one new in-service bit per clock
    a_r7_one_new_level: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_service_o & ~$past(in_service_o)) <= 1);

    // R6: in-service bits only appear with a vector
    a_r6_set_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_service_o & ~$past(in_service_o)) != '0) |-> vec_valid_o);
endmodule

bind vec_irq_ctrl ivc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_i        (ack_i),
    .irq_o        (irq_o),
    .vec_valid_o  (vec_valid_o),
    .in_service_o (in_service_o)
);

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0;
    logic       mask_we_i = 1'b0;
    logic [7:0] mask_wdata_i = '0;
    logic [7:0] vec_base_i = '0;
    logic       ack_i = 1'b0;
    logic       eoi_i = 1'b0;
    logic       irq_o;
    logic [7:0] vec_o;
    logic       vec_valid_o;
    logic [7:0] in_service_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vec_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_we_i(mask_we_i),
        .mask_wdata_i(mask_wdata_i), .vec_base_i(vec_base_i), .ack_i(ack_i),
        .eoi_i(eoi_i), .irq_o(irq_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o),
        .in_service_o(in_service_o)
    );

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_mask(input logic [7:0] m);
        mask_we_i = 1'b1; mask_wdata_i = m;
        step();
        mask_we_i = 1'b0;
    endtask

    task automatic pulse_eoi();
        eoi_i = 1'b1;
        step();
        eoi_i = 1'b0;
    endtask

    // acknowledge, then sample the clock that follows the grant edge
    task automatic do_ack();
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 irq", irq_o, 0);
        chk("R1 vec_valid", vec_valid_o, 0);
        chk("R1 in_service", in_service_o, 0);
        req_i = 8'hFF;
        step(4);
        chk("R1 all masked after reset", irq_o, 0);
        req_i = 8'h00;
        step(2);
    endtask

    task automatic t_basic();
        set_mask(8'h00);
        vec_base_i = 8'h40;
        req_i = 8'h04;
        step();
        chk("R2 irq not yet", irq_o, 0);
        step();
        chk("R2 irq raised", irq_o, 1);
        step(3);
        chk("R2 irq held", irq_o, 1);
        do_ack();
        chk("R3 vec_valid", vec_valid_o, 1);
        chk("R3 vector", vec_o, 8'h42);
        chk("R3 irq falls", irq_o, 0);
        chk("R6 bit set", in_service_o, 8'h04);
        step();
        chk("R3 one clock", vec_valid_o, 0);
        step(3);
        chk("R6 same level held off", irq_o, 0);
        req_i = 8'h00;
        step();
        pulse_eoi();
        chk("R8 retired", in_service_o, 8'h00);
        step(2);
    endtask

    task automatic t_priority();
        vec_base_i = 8'h10;
        req_i = 8'b0010_1001;
        step(2);
        chk("R4 irq", irq_o, 1);
        do_ack();
        chk("R4 highest wins", vec_o, 8'h15);
        chk("R4 isr", in_service_o, 8'h20);
        req_i = 8'h00;
        step(2);
        pulse_eoi();
        chk("R8 retired", in_service_o, 8'h00);
        step(2);
    endtask

    task automatic t_mask();
        set_mask(8'h20);
        req_i = 8'h20;
        step(4);
        chk("R5 masked source silent", irq_o, 0);
        req_i = 8'h22;
        step(2);
        chk("R5 irq for unmasked", irq_o, 1);
        do_ack();
        chk("R5 masked never wins", vec_o, 8'h11);
        chk("R5 isr", in_service_o, 8'h02);
        req_i = 8'h00;
        step(2);
        pulse_eoi();
        set_mask(8'h00);
        step(2);
    endtask

    task automatic t_nest();
        vec_base_i = 8'h80;
        req_i = 8'h02;
        step(2);
        do_ack();
        chk("R6 low level in service", in_service_o, 8'h02);
        req_i = 8'h03;
        step(4);
        chk("R6 lower and equal held off", irq_o, 0);
        req_i = 8'h43;
        step(2);
        chk("R7 preempt irq", irq_o, 1);
        do_ack();
        chk("R7 nested vector", vec_o, 8'h86);
        chk("R7 both levels", in_service_o, 8'h42);
        req_i = 8'h00;
        step(2);
        pulse_eoi();
        chk("R8 only top cleared", in_service_o, 8'h02);
        pulse_eoi();
        chk("R8 second cleared", in_service_o, 8'h00);
        step(2);
    endtask

    task automatic t_drop();
        req_i = 8'h10;
        step(2);
        chk("R9 irq up", irq_o, 1);
        req_i = 8'h00;
        step(2);
        chk("R9 irq withdrawn", irq_o, 0);
        do_ack();
        chk("R9 no vector", vec_valid_o, 0);
        chk("R9 isr unchanged", in_service_o, 8'h00);
        step(2);
    endtask

    task automatic t_wrap();
        vec_base_i = 8'hFE;
        req_i = 8'h08;
        step(2);
        do_ack();
        chk("R10 wrapped vector", vec_o, 8'h01);
        req_i = 8'h00;
        step(2);
        pulse_eoi();
        step(2);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_priority();
        t_mask();
        t_nest();
        t_drop();
        t_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule